// File: doc/BRIEF.md
# Programmed-I/O Channel Device Responder

This block is the device-side front end of a peripheral that sits on a shared 16-bit parallel programmed-I/O channel. The host places an address word on the channel and raises either a read request or a write request. Every attached device sees the same address word. Each device compares a 4-bit field of that word with its own strapped device number. Only the device whose number matches may answer. The others stay silent and keep off the data bus.

The lowest address bit selects the kind of word that moves. Combined with the request direction, it steers the transfer onto one of four internal paths: data out, data in, control word out, or condition word in. The responder waits a parameterised number of clocks, which is kept well inside the channel's timeout. It then either completes a four-phase handshake with an acknowledge, or answers with a refusal.

A refusal is given in these cases:
- the transfer cannot be done because there is no data to read or no room to write;
- the device is not ready and the request is a data transfer;
- the device is strapped as guarded, the host's permission line is low, and the request is anything other than a condition read.

The back end that decodes control words and builds the condition word is outside this block. It connects through one-cycle strobes, a captured write word, and the read and condition inputs.

Top module: `pio_slot_responder`

## Requirements
- R1: The device number is taken from address bits 10 down to 7. Bits 15 to 11 and 6 to 1 have no effect. When that field differs from `strap_id`, the block raises neither `reply` nor `reject`, keeps `bus_oe` low, and pulses no strobe.
- R2: The path is chosen by address bit 0 (`dir`) and the request direction, and each accepted transfer pulses exactly one strobe for one cycle:
  - write with `dir`=0 pulses `data_wr_stb`;
  - read with `dir`=0 pulses `data_rd_stb`;
  - write with `dir`=1 pulses `func_wr_stb`;
  - read with `dir`=1 pulses `stat_rd_stb`.
- R3: On an accepted read, `bus_out` carries the word and `bus_oe` is high at least one cycle before `reply` rises. `bus_out` carries `rd_data` for `dir`=0 and `status_word` for `dir`=1. `reply` stays high while `rd_req` is held. `reply` falls in the cycle after `rd_req` falls. `bus_oe` falls one cycle after `reply` falls.
- R4: On an accepted write, `bus_in` is captured into `wr_word`. `reply` stays high while `wr_req` is held and falls in the cycle after `wr_req` falls.
- R5: A data read with `rd_avail` low, or a data write with `wr_room` low, is answered with `reject` instead of `reply`, and no strobe is pulsed. `reject` is held until the request falls. `reply` and `reject` are never high together.
- R6: When `dev_guarded` is high and `prot_ok` is low, every path except the condition read (read, `dir`=1) is rejected.
- R7: When `dev_ready` is low, data reads and data writes are rejected. Control-word writes and condition reads are still accepted.
- R8: With a response delay of `RESP_DLY` clocks, counted in clock edges from the first edge that sees the request:
  - a read `reply` appears after `RESP_DLY`+2 edges;
  - a write `reply` appears after `RESP_DLY`+1 edges;
  - a `reject` appears after `RESP_DLY`+1 edges.
- R9: When `narrow_mode` is high, `char_in` is high while an accepted transfer is acknowledged or the bus is driven. Bits 15 to 8 of `bus_out` and of the captured `wr_word` are zero. `char_in` is low whenever `reply` and `bus_oe` are both low.
- R10: After reset, `reply`, `reject`, `bus_oe`, `char_in`, all strobes and `bus_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_id | input | 4 | Strapped device number |
| dev_guarded | input | 1 | Device is strapped as guarded |
| dev_ready | input | 1 | Device ready for data transfers |
| narrow_mode | input | 1 | Transfers carry only the low 8 bits |
| addr_word | input | 16 | Channel address word |
| rd_req | input | 1 | Host read request |
| wr_req | input | 1 | Host write request |
| prot_ok | input | 1 | Host permission to access guarded devices |
| bus_in | input | 16 | Channel data from host |
| rd_data | input | 16 | Back-end data word for data reads |
| status_word | input | 16 | Back-end condition word |
| rd_avail | input | 1 | Back end has read data |
| wr_room | input | 1 | Back end can take write data |
| bus_out | output | 16 | Channel data to host (zero when not driven) |
| bus_oe | output | 1 | Data bus drive enable |
| reply | output | 1 | Acknowledge |
| reject | output | 1 | Refusal |
| char_in | output | 1 | Narrow-transfer indication |
| wr_word | output | 16 | Captured write word |
| data_wr_stb | output | 1 | Data write strobe |
| data_rd_stb | output | 1 | Data read strobe |
| func_wr_stb | output | 1 | Control-word write strobe |
| stat_rd_stb | output | 1 | Condition read strobe |

## Verification
A wrong latched path shows up as the wrong strobe, or as the wrong word on `bus_out`, within `RESP_DLY`+2 cycles of the request. A bad acceptance decision turns an expected `reply` into a `reject`, or the reverse, at exactly `RESP_DLY`+1 edges. A handshake state that is stuck or skips a step shows up within one cycle of the request falling:
- `reply` or `reject` fails to drop; or
- the data bus is released before the acknowledge drops, or is left driven afterwards.

An address compare that uses the wrong bits shows up as a response on a mismatching word, or as silence on a matching word whose ignored bits are set.

// File: rtl/pio_resp_pkg.sv
package pio_resp_pkg;
  // path code = {dir, is_read}
  typedef enum logic [1:0] {
    PATH_DWR  = 2'b00,
    PATH_DRD  = 2'b01,
    PATH_FWR  = 2'b10,
    PATH_STAT = 2'b11
  } path_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DRIVE = 3'd2,
    ST_ACK   = 3'd3,
    ST_REL   = 3'd4,
    ST_NAK   = 3'd5
  } xfer_st_e;
endpackage

// File: rtl/pio_addr_match.sv
module pio_addr_match
  import pio_resp_pkg::*;
#(
  parameter int AW     = 16,
  parameter int ID_W   = 4,
  parameter int ID_LSB = 7
) (
  input  logic [AW-1:0]   addr_word,
  input  logic [ID_W-1:0] strap_id,
  input  logic            rd_req,
  input  logic            wr_req,
  output logic            hit,
  output path_e           path
);
  localparam int ID_MSB = ID_LSB + ID_W - 1;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr_word[AW-1:ID_MSB+1], addr_word[ID_LSB-1:1]};

  // only one request direction at a time is a valid access
  assign hit  = (addr_word[ID_MSB:ID_LSB] == strap_id) && (rd_req ^ wr_req);
  assign path = path_e'({addr_word[0], rd_req});
endmodule

// File: rtl/pio_accept_check.sv
module pio_accept_check
  import pio_resp_pkg::*;
(
  input  path_e path,
  input  logic  dev_guarded,
  input  logic  prot_ok,
  input  logic  dev_ready,
  input  logic  rd_avail,
  input  logic  wr_room,
  output logic  accept
);
  logic guard_block;
  logic ready_block;
  logic flow_block;

  always_comb begin
    guard_block = dev_guarded && !prot_ok && (path != PATH_STAT);
    ready_block = !dev_ready && ((path == PATH_DRD) || (path == PATH_DWR));
    flow_block  = ((path == PATH_DRD) && !rd_avail) ||
                  ((path == PATH_DWR) && !wr_room);
    accept      = !(guard_block || ready_block || flow_block);
  end
endmodule

// File: rtl/pio_xfer_fsm.sv
module pio_xfer_fsm
  import pio_resp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CHAR_W   = 8,
  parameter int RESP_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  path_e         path_in,
  input  logic          accept,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          narrow_mode,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] status_word,
  input  logic [DW-1:0] bus_in,
  output path_e         path_q,
  output logic          reply,
  output logic          reject,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] wr_word,
  output logic [3:0]    strobes,
  output logic          char_in
);
  localparam int CW = (RESP_DLY < 2) ? 1 : $clog2(RESP_DLY);
  localparam logic [CW-1:0] CNT_LAST = CW'(RESP_DLY - 1);

  xfer_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  path_e         path_d;
  logic [3:0]    stb_d, stb_q;
  logic [DW-1:0] dat_q, dat_d;
  logic          dat_en;
  logic [DW-1:0] wrw_q;
  logic          wrw_en;
  logic          cur_req;
  logic [DW-1:0] keep_mask;

  assign keep_mask = {{(DW-CHAR_W){~narrow_mode}}, {CHAR_W{1'b1}}};
  assign cur_req   = path_q[0] ? rd_req : wr_req;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    path_d = path_q;
    stb_d  = '0;
    dat_en = 1'b0;
    wrw_en = 1'b0;
    dat_d  = ((path_q == PATH_STAT) ? status_word : rd_data) & keep_mask;
    unique case (st_q)
      ST_IDLE: begin
        if (hit) begin
          st_d   = ST_WAIT;
          cnt_d  = '0;
          path_d = path_in;
        end
      end
      ST_WAIT: begin
        if (!cur_req) begin
          st_d = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          if (accept) begin
            stb_d[path_q] = 1'b1;
            if (path_q[0]) begin
              st_d   = ST_DRIVE;
              dat_en = 1'b1;
            end else begin
              st_d   = ST_ACK;
              wrw_en = 1'b1;
            end
          end else begin
            st_d = ST_NAK;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DRIVE: st_d = ST_ACK;
      ST_ACK:   if (!cur_req) st_d = path_q[0] ? ST_REL : ST_IDLE;
      ST_REL:   st_d = ST_IDLE;
      ST_NAK:   if (!cur_req) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      path_q <= PATH_DWR;
      stb_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      path_q <= path_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      wrw_q <= '0;
    end else begin
      if (dat_en) dat_q <= dat_d;
      if (wrw_en) wrw_q <= bus_in & keep_mask;
    end
  end

  assign reply   = (st_q == ST_ACK);
  assign reject  = (st_q == ST_NAK);
  assign bus_oe  = path_q[0] && ((st_q == ST_DRIVE) || (st_q == ST_ACK) || (st_q == ST_REL));
  assign bus_out = bus_oe ? dat_q : '0;
  assign wr_word = wrw_q;
  assign strobes = stb_q;
  assign char_in = narrow_mode && (reply || bus_oe);
endmodule

// File: rtl/pio_slot_responder.sv
module pio_slot_responder
  import pio_resp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ID_W     = 4,
  parameter int ID_LSB   = 7,
  parameter int CHAR_W   = 8,
  parameter int RESP_DLY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] strap_id,
  input  logic            dev_guarded,
  input  logic            dev_ready,
  input  logic            narrow_mode,
  input  logic [DW-1:0]   addr_word,
  input  logic            rd_req,
  input  logic            wr_req,
  input  logic            prot_ok,
  input  logic [DW-1:0]   bus_in,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   status_word,
  input  logic            rd_avail,
  input  logic            wr_room,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  output logic            reply,
  output logic            reject,
  output logic            char_in,
  output logic [DW-1:0]   wr_word,
  output logic            data_wr_stb,
  output logic            data_rd_stb,
  output logic            func_wr_stb,
  output logic            stat_rd_stb
);
  logic       hit;
  path_e      path_in;
  path_e      path_q;
  logic       accept;
  logic [3:0] strobes;

  pio_addr_match #(.AW(DW), .ID_W(ID_W), .ID_LSB(ID_LSB)) match_i (
    .addr_word(addr_word), .strap_id(strap_id), .rd_req(rd_req),
    .wr_req(wr_req), .hit(hit), .path(path_in)
  );

  pio_accept_check accept_i (
    .path(path_q), .dev_guarded(dev_guarded), .prot_ok(prot_ok),
    .dev_ready(dev_ready), .rd_avail(rd_avail), .wr_room(wr_room),
    .accept(accept)
  );

  pio_xfer_fsm #(.DW(DW), .CHAR_W(CHAR_W), .RESP_DLY(RESP_DLY)) fsm_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .path_in(path_in), .accept(accept),
    .rd_req(rd_req), .wr_req(wr_req), .narrow_mode(narrow_mode),
    .rd_data(rd_data), .status_word(status_word), .bus_in(bus_in),
    .path_q(path_q), .reply(reply), .reject(reject), .bus_oe(bus_oe),
    .bus_out(bus_out), .wr_word(wr_word), .strobes(strobes), .char_in(char_in)
  );

  assign data_wr_stb = strobes[PATH_DWR];
  assign data_rd_stb = strobes[PATH_DRD];
  assign func_wr_stb = strobes[PATH_FWR];
  assign stat_rd_stb = strobes[PATH_STAT];
endmodule

// File: rtl/pio_resp_chk.sv
module pio_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic wr_req,
  input logic reply,
  input logic reject,
  input logic bus_oe,
  input logic char_in,
  input logic dev_guarded,
  input logic prot_ok,
  input logic data_wr_stb,
  input logic data_rd_stb,
  input logic func_wr_stb,
  input logic stat_rd_stb
);
  p_one_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply && reject));

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_wr_stb, data_rd_stb, func_wr_stb, stat_rd_stb}));

  p_drive_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply) && bus_oe |-> $past(bus_oe));

  p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reply && bus_oe && rd_req |=> reply);

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reply && !bus_oe && wr_req |=> reply);

  p_drop_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reply && !rd_req && !wr_req |=> !reply);

  p_release_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reply) && bus_oe |=> !bus_oe);

  p_nak_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reject && (rd_req || wr_req) |=> reject);

  p_guard_status_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply) && dev_guarded && !prot_ok |-> $past(stat_rd_stb));

  p_char_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    char_in |-> (reply || bus_oe));
endmodule

bind pio_slot_responder pio_resp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
  .reply(reply), .reject(reject), .bus_oe(bus_oe), .char_in(char_in),
  .dev_guarded(dev_guarded), .prot_ok(prot_ok),
  .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb),
  .func_wr_stb(func_wr_stb), .stat_rd_stb(stat_rd_stb)
);

// File: tb/pio_slot_responder_tb.sv
`timescale 1ns/1ps
module pio_slot_responder_tb_top;
  localparam int D = 3;
  localparam logic [3:0] MY_ID = 4'hB;
  localparam logic [15:0] RD_WORD = 16'hA5C3;
  localparam logic [15:0] ST_WORD = 16'h0123;

  // [13] rd [12] dir [11] guarded [10] prot_ok [9] ready [8] avail [7] room
  // [6] id match [5:4] expect (0 none, 1 reply, 2 reject) [3:0] strobe {stat,fwr,drd,dwr}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b0_0_0_0_1_0_1_1_01_0001, // R2 R4 data write
    14'b1_0_0_0_1_1_0_1_01_0010, // R2 R3 data read
    14'b0_1_0_0_1_0_0_1_01_0100, // R2 function write
    14'b1_1_0_0_1_0_0_1_01_1000, // R2 status read
    14'b1_0_0_0_1_0_0_1_10_0000, // R5 read, no data
    14'b0_0_0_0_1_0_0_1_10_0000, // R5 write, no room
    14'b0_0_1_0_1_0_1_1_10_0000, // R6 guarded data write
    14'b0_1_1_0_1_0_1_1_10_0000, // R6 guarded function write
    14'b1_1_1_0_1_0_0_1_01_1000, // R6 guarded status read allowed
    14'b1_0_1_1_1_1_0_1_01_0010, // R6 guarded with permission
    14'b1_0_0_0_0_1_0_1_10_0000, // R7 not ready data read
    14'b0_1_0_0_0_0_0_1_01_0100, // R7 not ready function write
    14'b1_1_0_0_0_0_0_1_01_1000, // R7 not ready status read
    14'b1_0_0_0_1_1_1_0_00_0000  // R1 mismatch
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] strap_id;
  logic dev_guarded, dev_ready, narrow_mode, rd_req, wr_req, prot_ok, rd_avail, wr_room;
  logic [15:0] addr_word, bus_in, rd_data, status_word, bus_out, wr_word;
  logic bus_oe, reply, reject, char_in;
  logic data_wr_stb, data_rd_stb, func_wr_stb, stat_rd_stb;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pio_slot_responder #(.RESP_DLY(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .dev_guarded(dev_guarded),
    .dev_ready(dev_ready), .narrow_mode(narrow_mode), .addr_word(addr_word),
    .rd_req(rd_req), .wr_req(wr_req), .prot_ok(prot_ok), .bus_in(bus_in),
    .rd_data(rd_data), .status_word(status_word), .rd_avail(rd_avail),
    .wr_room(wr_room), .bus_out(bus_out), .bus_oe(bus_oe), .reply(reply),
    .reject(reject), .char_in(char_in), .wr_word(wr_word),
    .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb),
    .func_wr_stb(func_wr_stb), .stat_rd_stb(stat_rd_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input bit rd, input bit dir, input logic [3:0] id,
                          input logic [1:0] exp, input logic [3:0] stb,
                          input logic [15:0] wdat, input string req);
    int n = 0;
    bit done = 0;
    bit oe_early = 0;
    bit oe_any = 0;
    logic [3:0] acc = '0;
    logic [15:0] mask;
    mask = narrow_mode ? 16'h00FF : 16'hFFFF;
    addr_word = {5'b10110, id, 6'b000000, dir};
    bus_in = wdat;
    rd_req = rd;
    wr_req = !rd;
    for (int k = 0; k < 12 && !done; k++) begin
      @(negedge clk);
      n++;
      acc |= {stat_rd_stb, func_wr_stb, data_rd_stb, data_wr_stb};
      if (bus_oe) oe_any = 1;
      if (bus_oe && !reply) oe_early = 1;
      if (reply || reject) done = 1;
    end
    if (exp == 2'd0) begin
      chk(!done && !oe_any && acc == 4'd0, req, "silent on mismatch",
          {oe_any, done, acc}, 0);
    end else begin
      chk(reply == (exp == 2'd1) && reject == (exp == 2'd2), req, "answer kind",
          {reply, reject}, {exp == 2'd1, exp == 2'd2});
      chk(n == ((exp == 2'd1 && rd) ? D + 2 : D + 1), "R8", "latency", n,
          (exp == 2'd1 && rd) ? D + 2 : D + 1);
      chk(acc == stb, "R2", "strobe", acc, stb);
      if (exp == 2'd1 && rd) begin
        chk(oe_early, "R3", "bus driven before reply", oe_early, 1);
        chk(bus_out == ((dir ? ST_WORD : RD_WORD) & mask), "R3", "read word",
            bus_out, (dir ? ST_WORD : RD_WORD) & mask);
        chk(char_in == narrow_mode, "R9", "char_in on read", char_in, narrow_mode);
      end
      if (exp == 2'd1 && !rd)
        chk(wr_word == (wdat & mask), "R4", "captured word", wr_word, wdat & mask);
      @(negedge clk);
      chk(reply == (exp == 2'd1) && reject == (exp == 2'd2), req,
          "answer held", {reply, reject}, {exp == 2'd1, exp == 2'd2});
    end
    rd_req = 0;
    wr_req = 0;
    @(negedge clk);
    chk(!reply && !reject, req, "answer drops after request", {reply, reject}, 0);
    if (exp == 2'd1 && rd) begin
      chk(bus_oe, "R3", "bus held one cycle after reply", bus_oe, 1);
      @(negedge clk);
      chk(!bus_oe && bus_out == 16'h0, "R3", "bus released", {bus_oe, bus_out}, 0);
    end
    chk(!char_in, "R9", "char_in idle low", char_in, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    strap_id = MY_ID;
    dev_guarded = 0; dev_ready = 1; narrow_mode = 0;
    addr_word = '0; rd_req = 0; wr_req = 0; prot_ok = 0;
    bus_in = '0; rd_data = RD_WORD; status_word = ST_WORD;
    rd_avail = 0; wr_room = 0;
    repeat (3) @(negedge clk);
    chk(!reply && !reject && !bus_oe && !char_in && bus_out == 0 &&
        {data_wr_stb, data_rd_stb, func_wr_stb, stat_rd_stb} == 0,
        "R10", "reset outputs", {reply, reject, bus_oe, char_in}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!reply && !reject && !bus_oe, "R10", "idle after reset",
        {reply, reject, bus_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      dev_guarded = v[11]; prot_ok = v[10]; dev_ready = v[9];
      rd_avail = v[8]; wr_room = v[7];
      run_xfer(v[13], v[12], v[6] ? MY_ID : 4'h4, v[5:4], v[3:0],
               16'h9E70 + 16'(i), $sformatf("vec%0d R1/R2", i));
    end

    // R9 narrow read and write
    dev_guarded = 0; prot_ok = 0; dev_ready = 1; rd_avail = 1; wr_room = 1;
    narrow_mode = 1;
    run_xfer(1, 0, MY_ID, 2'd1, 4'b0010, 16'h0, "R9 narrow read");
    run_xfer(0, 0, MY_ID, 2'd1, 4'b0001, 16'h9E71, "R9 narrow write");
    run_xfer(1, 1, MY_ID, 2'd1, 4'b1000, 16'h0, "R9 narrow status");
    narrow_mode = 0;

    // R1 ignored high bits with a different pattern: still answers
    rd_req = 1;
    addr_word = {5'b01001, MY_ID, 6'b111111, 1'b0};
    repeat (D + 2) @(negedge clk);
    chk(reply && bus_out == RD_WORD, "R1", "ignored bits have no effect",
        {reply, bus_out}, {1'b1, RD_WORD});
    rd_req = 0;
    repeat (3) @(negedge clk);
    chk(!reply && !bus_oe, "R1", "back to idle", {reply, bus_oe}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule